// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core. It finishes each instruction within one clock period and has no pipeline registers. It runs a small load/store instruction subset:

- register-register add, subtract, AND, OR and signed set-less-than;
- word load and word store;
- branch-if-equal.

Inside the core are the program counter, a 32-entry register file, an ALU, an immediate sign extender, the next-PC logic and the instruction decoder. The core drives an instruction-memory address and receives the instruction word back in the same cycle. It drives a data-memory address, write data and a write strobe, and receives the read data in the same cycle.

Both memory ports are plain combinational read ports. They carry no valid/ready handshake, so there is no back-pressure: the core assumes every memory answers within the cycle. A store is committed at the rising clock edge on which `dmem_we` is high. A memory that cannot keep up cannot stall the core.

Instruction fields sit at fixed positions:

| Field | Bits | Used by |
|-------|------|---------|
| opcode | [31:26] | all |
| source A | [25:21] | all |
| source B / load target | [20:16] | all |
| R-type destination | [15:11] | register-register |
| shift | [10:6] | register-register |
| function | [5:0] | register-register |
| 16-bit offset | [15:0] | load, store, branch |

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0 and clears every register. On the first cycle after reset is released, `imem_addr` is 0.
- R2: Every instruction other than a taken branch advances the PC by exactly 4.
- R3: Opcode 0x00 is register-register. With shift field 0, these function codes write into the register named by bits [15:11]:
  - 0x21 writes A+B;
  - 0x23 writes A-B;
  - 0x24 writes A AND B;
  - 0x25 writes A OR B.
  A is the register named by bits [25:21] and B the register named by bits [20:16].
- R4: Function code 0x2A writes 1 into the destination when A is less than B in a signed, two's-complement comparison, and writes 0 otherwise.
- R5: Opcode 0x23 (load) forms the address A + sign-extended offset[15:0]. It writes the data-memory word at that address into the register named by bits [20:16]. Negative offsets work.
- R6: Opcode 0x2B (store) forms the same address, raises `dmem_we` and drives `dmem_wdata` with the register named by bits [20:16]. It changes no register. `dmem_we` is never high for any other instruction.
- R7: Opcode 0x04 (branch) compares A with B. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2; this includes backward targets. When they differ, the next PC is PC+4.
- R8: Register 0 always reads as zero, and a write aimed at it is discarded.
- R9: The following are executed as no-ops that only advance the PC by 4, with no register or memory write:
  - any other opcode;
  - any other function code;
  - a register-register word with a nonzero shift field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_we | output | 1 | Data-memory write strobe, taken on the rising edge |
| dmem_addr | output | 32 | Data-memory byte address |
| dmem_wdata | output | 32 | Data-memory write data |
| dmem_rdata | input | 32 | Data-memory word at `dmem_addr`, same cycle |

## Verification
The register file cannot be seen from the ports, so the hardest cases are the ones whose only effect is on register contents: a discarded write to register 0, a no-op that must leave its would-be destination alone, and a store that must not write back. The program drives each case and then stores the affected register to memory, so the store stream carries the evidence. Branch behaviour is made visible by order: the outcome of a branch decides which stores appear. A taken branch steps over two stores that would be flagged as unexpected, and the program ends in a backward self-loop whose final PC is checked.

// File: rtl/sc_pkg.sv
package sc_pkg;

  // primary opcodes, bits [31:26]
  localparam logic [5:0] OP_REG   = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  // function codes, bits [5:0], when opcode is OP_REG
  localparam logic [5:0] FN_ADD = 6'h21;
  localparam logic [5:0] FN_SUB = 6'h23;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;       // write back to the register file
    logic    dst_is_rd;    // destination from [15:11] instead of [20:16]
    logic    b_is_imm;     // ALU operand B is the extended offset
    logic    wb_from_mem;  // write-back value comes from data memory
    logic    mem_we;       // store
    logic    is_branch;    // branch-if-equal
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   ra_a,
  input  logic [AW-1:0]   ra_b,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b
);
  localparam int NREG = 1 << AW;

  logic [XLEN-1:0] regs [NREG];

  // synchronous write; index 0 is never written
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  // asynchronous reads, index 0 forced to zero
  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = XLEN'($signed(a) < $signed(b));
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;  // default: no-op, ALU add
    unique case (opcode)
      OP_REG: begin
        if (shamt == '0) begin
          unique case (funct)
            FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_ADD; end
            FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_SUB; end
            FN_AND: begin ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_AND; end
            FN_OR:  begin ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_OR;  end
            FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.dst_is_rd = 1'b1; ctrl.alu_op = ALU_SLT; end
            default: ;
          endcase
        end
      end
      OP_LOAD: begin
        ctrl.reg_we      = 1'b1;
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      OP_STORE: begin
        ctrl.mem_we   = 1'b1;
        ctrl.b_is_imm = 1'b1;
      end
      OP_BEQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_nextpc.sv
module sc_nextpc #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic [15:0]     offset,
  input  logic            take,
  output logic [XLEN-1:0] pc_next
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_inc;
  logic [XLEN-1:0] disp;

  assign pc_inc  = pc + STEP;
  assign disp    = {{(XLEN-18){offset[15]}}, offset, 2'b00};
  assign pc_next = take ? (pc_inc + disp) : pc_inc;

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam int AW = 5;

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_next;

  // instruction fields
  logic [5:0]    f_op;
  logic [AW-1:0] f_rs;
  logic [AW-1:0] f_rt;
  logic [AW-1:0] f_rd;
  logic [4:0]    f_sh;
  logic [5:0]    f_fn;
  logic [15:0]   f_imm;

  assign f_op  = imem_rdata[31:26];
  assign f_rs  = imem_rdata[25:21];
  assign f_rt  = imem_rdata[20:16];
  assign f_rd  = imem_rdata[15:11];
  assign f_sh  = imem_rdata[10:6];
  assign f_fn  = imem_rdata[5:0];
  assign f_imm = imem_rdata[15:0];

  ctrl_t           ctrl;
  logic [XLEN-1:0] rs_data;
  logic [XLEN-1:0] rt_data;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_y;
  logic            alu_zero;
  logic [AW-1:0]   wr_idx;
  logic [XLEN-1:0] wr_val;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  sc_decode u_dec (
    .opcode (f_op),
    .shamt  (f_sh),
    .funct  (f_fn),
    .ctrl   (ctrl)
  );

  assign wr_idx = ctrl.dst_is_rd ? f_rd : f_rt;
  assign wr_val = ctrl.wb_from_mem ? dmem_rdata : alu_y;

  sc_regfile #(.XLEN(XLEN), .AW(AW)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .ra_a (f_rs),
    .ra_b (f_rt),
    .we   (ctrl.reg_we),
    .wa   (wr_idx),
    .wd   (wr_val),
    .rd_a (rs_data),
    .rd_b (rt_data)
  );

  assign imm_ext = {{(XLEN-16){f_imm[15]}}, f_imm};
  assign alu_b   = ctrl.b_is_imm ? imm_ext : rt_data;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .op   (ctrl.alu_op),
    .a    (rs_data),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  sc_nextpc #(.XLEN(XLEN)) u_npc (
    .pc      (pc_q),
    .offset  (f_imm),
    .take    (ctrl.is_branch & alu_zero),
    .pc_next (pc_next)
  );

  assign imem_addr  = pc_q;
  assign dmem_we    = ctrl.mem_we;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_data;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] imem_addr,
  input logic [31:0]     imem_rdata,
  input logic            dmem_we,
  input logic [XLEN-1:0] dmem_addr,
  input logic [XLEN-1:0] dmem_wdata,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val
);
  logic [5:0]      c_op;
  logic [5:0]      c_fn;
  logic [XLEN-1:0] c_sext;
  logic            c_known;

  assign c_op   = imem_rdata[31:26];
  assign c_fn   = imem_rdata[5:0];
  assign c_sext = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};
  assign c_known = (c_op == OP_LOAD) || (c_op == OP_STORE) || (c_op == OP_BEQ) ||
                   ((c_op == OP_REG) && (imem_rdata[10:6] == 5'd0) &&
                    ((c_fn == FN_ADD) || (c_fn == FN_SUB) || (c_fn == FN_AND) ||
                     (c_fn == FN_OR)  || (c_fn == FN_SLT)));

  // R1
  reset_pc_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> imem_addr == '0);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (c_op != OP_BEQ) |=> imem_addr == $past(imem_addr) + XLEN'(4));

  // R5
  load_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (c_op == OP_LOAD) |-> dmem_addr == rs_val + c_sext);

  // R6
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (c_op == OP_STORE) && (dmem_wdata == rt_val) &&
                (dmem_addr == rs_val + c_sext));

  // R7
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (c_op == OP_BEQ) && (rs_val == rt_val) |=>
      imem_addr == $past(imem_addr) + XLEN'(4) + ($past(c_sext) << 2));

  // R7
  branch_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (c_op == OP_BEQ) && (rs_val != rt_val) |=> imem_addr == $past(imem_addr) + XLEN'(4));

  // R8
  zero_src_a_chk: assert property (@(posedge clk) disable iff (rst)
    (imem_rdata[25:21] == 5'd0) |-> rs_val == '0);

  // R8
  zero_src_b_chk: assert property (@(posedge clk) disable iff (rst)
    (imem_rdata[20:16] == 5'd0) |-> rt_val == '0);

  // R9
  unknown_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    !c_known |-> !dmem_we);

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_we    (dmem_we),
  .dmem_addr  (dmem_addr),
  .dmem_wdata (dmem_wdata),
  .rs_val     (rs_data),
  .rt_val     (rt_data)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEMW       = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata;
  logic        dmem_we;
  logic [31:0] dmem_addr;
  logic [31:0] dmem_wdata;
  logic [31:0] dmem_rdata;

  logic [31:0] imem [MEMW];
  logic [31:0] dmem [MEMW];

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // scoreboard queues
  logic [31:0] q_addr [$];
  logic [31:0] q_data [$];
  string       q_tag  [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  sc_core dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [4:0] sh,
                                        input logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_store(input logic [31:0] a, input logic [31:0] d, input string tag);
    q_addr.push_back(a);
    q_data.push_back(d);
    q_tag.push_back(tag);
  endtask

  // monitor: compares each store the core issues with the next expected item
  always @(negedge clk) begin
    if (!rst && dmem_we && !done) begin
      n_cmp++;
      if (q_addr.size() == 0) begin
        n_bad++;
        $display("FAIL R7 unexpected store: actual addr=%h data=%h expected none",
                 dmem_addr, dmem_wdata);
      end else begin
        logic [31:0] ea;
        logic [31:0] ed;
        string       et;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        et = q_tag.pop_front();
        if (dmem_addr !== ea || dmem_wdata !== ed) begin
          n_bad++;
          $display("FAIL %s: actual addr=%h data=%h expected addr=%h data=%h",
                   et, dmem_addr, dmem_wdata, ea, ed);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < MEMW; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
    dmem[0] = 32'd5;
    dmem[1] = 32'hFFFF_FFFD;
    dmem[2] = 32'h0F0F_00FF;
    dmem[3] = 32'h00FF_0FF0;
    dmem[4] = 32'd96;

    imem[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'd0);       // r1 = 5
    imem[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'd4);       // r2 = -3
    imem[2]  = enc_i(6'h23, 5'd0, 5'd3, 16'd8);
    imem[3]  = enc_i(6'h23, 5'd0, 5'd4, 16'd12);
    imem[4]  = enc_r(5'd1, 5'd2, 5'd5, 5'd0, 6'h21);  // add
    imem[5]  = enc_r(5'd1, 5'd2, 5'd6, 5'd0, 6'h23);  // sub
    imem[6]  = enc_r(5'd3, 5'd4, 5'd7, 5'd0, 6'h24);  // and
    imem[7]  = enc_r(5'd3, 5'd4, 5'd8, 5'd0, 6'h25);  // or
    imem[8]  = enc_r(5'd2, 5'd1, 5'd9, 5'd0, 6'h2A);  // -3 < 5
    imem[9]  = enc_r(5'd1, 5'd2, 5'd10, 5'd0, 6'h2A); // 5 < -3
    imem[10] = enc_r(5'd1, 5'd1, 5'd0, 5'd0, 6'h21);  // write to r0
    imem[11] = enc_i(6'h2B, 5'd0, 5'd5, 16'd64);
    imem[12] = enc_i(6'h2B, 5'd0, 5'd6, 16'd68);
    imem[13] = enc_i(6'h2B, 5'd0, 5'd7, 16'd72);
    imem[14] = enc_i(6'h2B, 5'd0, 5'd8, 16'd76);
    imem[15] = enc_i(6'h2B, 5'd0, 5'd9, 16'd80);
    imem[16] = enc_i(6'h2B, 5'd0, 5'd10, 16'd84);
    imem[17] = enc_i(6'h2B, 5'd0, 5'd0, 16'd88);
    imem[18] = enc_i(6'h3F, 5'd1, 5'd1, 16'h0840);    // unknown opcode
    imem[19] = enc_r(5'd1, 5'd1, 5'd1, 5'd0, 6'h3F);  // unknown funct
    imem[20] = enc_r(5'd1, 5'd1, 5'd1, 5'd3, 6'h21);  // add with shift field set
    imem[21] = enc_i(6'h2B, 5'd0, 5'd1, 16'd92);
    imem[22] = enc_i(6'h23, 5'd0, 5'd12, 16'd16);     // r12 = 96
    imem[23] = enc_i(6'h23, 5'd12, 5'd13, 16'hFFE0);  // r13 = mem[64]
    imem[24] = enc_i(6'h2B, 5'd12, 5'd13, 16'd4);     // mem[100] = r13
    imem[25] = enc_i(6'h04, 5'd1, 5'd2, 16'd5);       // not taken
    imem[26] = enc_i(6'h04, 5'd5, 5'd13, 16'd2);      // taken to 29
    imem[27] = enc_i(6'h2B, 5'd0, 5'd1, 16'd104);
    imem[28] = enc_i(6'h2B, 5'd0, 5'd1, 16'd108);
    imem[29] = enc_i(6'h2B, 5'd0, 5'd2, 16'd104);
    imem[30] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);    // self-loop

    expect_store(32'd64,  32'd2,          "R3 add");
    expect_store(32'd68,  32'd8,          "R3 sub");
    expect_store(32'd72,  32'h000F_00F0,  "R3 and");
    expect_store(32'd76,  32'h0FFF_0FFF,  "R3 or");
    expect_store(32'd80,  32'd1,          "R4 slt true");
    expect_store(32'd84,  32'd0,          "R4 slt false");
    expect_store(32'd88,  32'd0,          "R8 r0 write discarded");
    expect_store(32'd92,  32'd5,          "R9 no-ops kept r1");
    expect_store(32'd100, 32'd2,          "R5 load negative offset");
    expect_store(32'd104, 32'hFFFF_FFFD,  "R7 branch target");

    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 pc in reset", imem_addr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 pc step", imem_addr, 32'd4);

    repeat (60) @(negedge clk);
    check("R7 loop pc", imem_addr, 32'd120);
    check("R7 stores left", 32'(q_addr.size()), 32'd0);
    check("R6 memory written", dmem[25], 32'd2);
    check("R7 skipped store", dmem[27], 32'd0);
    finish_run();
  end

endmodule